// File: doc/BRIEF.md
# Data-Ready Handshake Generator

This block produces the active-low data-ready level that a host watches to know when a fresh set of conversion results can be fetched. A one-cycle strobe from the sampling-clock side announces each new result set. The output is then pulled low on that clock edge. The serial interface reports that the host has read the results by flipping a toggle line. That line is brought into the sampling-clock domain through a flop synchroniser, and a change on it is detected as a read. A detected read returns the output high.

New results always replace the old ones. Because of this, the host has exactly one result period in which to read. If new results arrive while the output is still low, meaning the previous set was never read, the block drives the output high for a fixed gap of sampling-clock periods. It then pulls the output low again, so the host always sees a distinct falling edge for each new result set. Once a gap has started it always runs to its full length.

Top module: `drdy_handshake`

## Requirements
- R1: While reset is held, and after reset until the first new-data strobe, `rdyN` is 1.
- R2: A new-data strobe sampled while `rdyN` is high and no gap is running drives `rdyN` to 0 from that clock edge on.
- R3: A change of `readToggle` while `rdyN` is low and no strobe coincides drives `rdyN` to 1 at the third rising clock edge at which the changed level is present.
- R4: A change of `readToggle` while `rdyN` is high and no gap is running has no effect: `rdyN` stays 1, and the next strobe pulls it low as in R2.
- R5: A new-data strobe sampled while `rdyN` is low makes `rdyN` 1 for exactly `GAP_LEN` (default 15) clock periods, after which it returns to 0.
- R6: A read detected during the gap neither shortens the gap nor cancels the re-assertion. `rdyN` still returns to 0 after `GAP_LEN` periods and then stays 0 until a later read.
- R7: A new-data strobe during the gap neither restarts nor extends it.
- R8: When a strobe and a detected read fall on the same clock edge while `rdyN` is low, the strobe takes priority and a gap starts as in R5.
- R9: After a gap ends, a read clears `rdyN` exactly as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| newData | input | 1 | One-cycle strobe, synchronous to `clk`, marking a new result set |
| readToggle | input | 1 | Flips once for each completed host read; may be asynchronous to `clk` |
| rdyN | output | 1 | Active-low data-ready level |

## Verification
The assertions assume that `newData` is a single-cycle strobe synchronous to `clk`. They also assume that `readToggle` changes at most once in any few sampling clocks, so that every flip shows up as exactly one detected read. The stimulus drives both inputs on the falling clock edge and spaces read flips at least four clocks apart. It lines up strobes with the detected-read edge only where the priority case (R8) is being exercised on purpose.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_GAP   = 2'd2
  } drdyState_e;

  typedef struct packed {
    logic setLow;
    logic setHigh;
    logic loadGap;
  } drdyCmd_t;
endpackage

// File: rtl/drdy_pulse_sync.sv
module drdy_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic toggleIn,
  output logic pulse
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[CHAIN_W-2:0], toggleIn};
  end

  // The last two taps differ for one cycle after each flip of the input.
  assign pulse = chain[CHAIN_W-1] ^ chain[CHAIN_W-2];
endmodule

// File: rtl/drdy_ctrl.sv
module drdy_ctrl
  import drdy_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     newData,
  input  logic     readPulse,
  input  logic     gapDone,
  output drdyCmd_t cmd
);
  drdyState_e state, stateNext;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE: begin
        if (newData) begin
          stateNext  = ST_READY;
          cmd.setLow = 1'b1;
        end
      end
      ST_READY: begin
        if (newData) begin
          // unread results are being replaced: new data wins over a read
          stateNext   = ST_GAP;
          cmd.loadGap = 1'b1;
          cmd.setHigh = 1'b1;
        end else if (readPulse) begin
          stateNext   = ST_IDLE;
          cmd.setHigh = 1'b1;
        end
      end
      ST_GAP: begin
        if (gapDone) begin
          stateNext  = ST_READY;
          cmd.setLow = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/drdy_datapath.sv
module drdy_datapath
  import drdy_pkg::*;
#(
  parameter int GAP_LEN = 15
) (
  input  logic     clk,
  input  logic     rstN,
  input  drdyCmd_t cmd,
  output logic     gapDone,
  output logic     rdyN
);
  localparam int CNT_W = $clog2(GAP_LEN + 1);
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_LEN - 1);

  logic [CNT_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                gapCnt <= '0;
    else if (cmd.loadGap)     gapCnt <= GAP_LOAD;
    else if (gapCnt != '0)    gapCnt <= gapCnt - 1'b1;
  end

  assign gapDone = (gapCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdyN <= 1'b1;
    else if (cmd.setLow)  rdyN <= 1'b0;
    else if (cmd.setHigh) rdyN <= 1'b1;
  end
endmodule

// File: rtl/drdy_handshake.sv
module drdy_handshake
  import drdy_pkg::*;
#(
  parameter int GAP_LEN     = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic newData,
  input  logic readToggle,
  output logic rdyN
);
  logic     readPulse;
  logic     gapDone;
  drdyCmd_t cmd;

  drdy_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .toggleIn(readToggle), .pulse(readPulse)
  );

  drdy_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .newData(newData), .readPulse(readPulse),
    .gapDone(gapDone), .cmd(cmd)
  );

  drdy_datapath #(.GAP_LEN(GAP_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .gapDone(gapDone), .rdyN(rdyN)
  );
endmodule

// File: rtl/drdy_handshake_chk.sv
module drdy_handshake_chk #(
  parameter int GAP_LEN = 15
) (
  input logic clk,
  input logic rstN,
  input logic newData,
  input logic readPulse,
  input logic rdyN
);
  localparam int W = $clog2(GAP_LEN + 1);

  logic         seenData;
  logic [W-1:0] gapLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        seenData <= 1'b0;
    else if (newData) seenData <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  gapLeft <= '0;
    else if (!rdyN && newData)  gapLeft <= W'(GAP_LEN);
    else if (gapLeft != '0)     gapLeft <= gapLeft - 1'b1;
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !seenData |-> rdyN);

  p_read_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyN && readPulse && !newData) |=> rdyN);

  // also covers R8: a strobe while low always opens a gap
  p_gap_open_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyN && newData) |=> rdyN);

  p_gap_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (gapLeft != '0) |-> rdyN);

  p_gap_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    (gapLeft == W'(1)) |=> !rdyN);

  p_fall_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyN) |-> ($past(newData) || ($past(gapLeft) == W'(1))));
endmodule

bind drdy_handshake drdy_handshake_chk #(.GAP_LEN(GAP_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .newData(newData), .readPulse(readPulse), .rdyN(rdyN)
);

// File: tb/sim_drdy_handshake.sv
module sim_drdy_handshake;
  localparam int GAP = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic newData = 1'b0;
  logic readToggle = 1'b0;
  logic rdyN;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;
  string curTag = "R1";

  // reference model state
  int mLevel = 1;
  int mMode = 0;     // 0 idle, 1 data waiting, 2 forced gap
  int mLeft = 0;
  int togQ[$];

  drdy_handshake #(.GAP_LEN(GAP), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .newData(newData), .readToggle(readToggle), .rdyN(rdyN)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      mLevel = 1; mMode = 0; mLeft = 0;
      togQ = '{0, 0, 0};
    end else begin
      bit rd;
      togQ.push_back(int'(readToggle));
      rd = (togQ[togQ.size()-3] != togQ[togQ.size()-4]);
      if (togQ.size() > 8) void'(togQ.pop_front());
      if (mMode == 0) begin
        if (newData) begin mMode = 1; mLevel = 0; end
      end else if (mMode == 1) begin
        if (newData) begin mMode = 2; mLevel = 1; mLeft = GAP - 1; end
        else if (rd) begin mMode = 0; mLevel = 1; end
      end else begin
        if (mLeft == 0) begin mMode = 1; mLevel = 0; end
        else mLeft = mLeft - 1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (!done) check(curTag, int'(rdyN), mLevel);

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finishRun();
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseNew();
    newData = 1'b1; tick(); newData = 1'b0;
  endtask

  task automatic flipRead();
    readToggle = ~readToggle;
  endtask

  // mode 0 plain, 1 read inside the gap, 2 strobe inside the gap
  task automatic measureGap(string tag, int mode);
    int n = 0;
    while (rdyN && n < 40) begin
      n++;
      if (mode == 1 && n == 3) flipRead();
      if (mode == 2 && n == 5) newData = 1'b1;
      @(negedge clk);
      newData = 1'b0;
    end
    check(tag, n, GAP);
  endtask

  initial begin
    curTag = "R1";
    tick(4);
    check("R1", int'(rdyN), 1);
    rstN = 1'b1;
    tick(5);
    check("R1", int'(rdyN), 1);

    curTag = "R4";
    flipRead(); tick(6);
    check("R4", int'(rdyN), 1);

    curTag = "R2";
    pulseNew();
    check("R2", int'(rdyN), 0);
    tick(5);

    curTag = "R3";
    flipRead(); tick(2);
    check("R3", int'(rdyN), 0);
    tick();
    check("R3", int'(rdyN), 1);
    tick(4);

    curTag = "R5";
    pulseNew(); tick(5);
    pulseNew();
    measureGap("R5", 0);
    check("R5", int'(rdyN), 0);
    tick(3);

    curTag = "R9";
    flipRead(); tick(4);
    check("R9", int'(rdyN), 1);

    curTag = "R6";
    pulseNew(); tick(3);
    pulseNew();
    measureGap("R6", 1);
    tick(6);
    check("R6", int'(rdyN), 0);

    curTag = "R7";
    pulseNew();
    measureGap("R7", 2);
    check("R7", int'(rdyN), 0);
    tick(4);

    curTag = "R8";
    flipRead(); tick(2);
    pulseNew();
    measureGap("R8", 0);
    check("R8", int'(rdyN), 0);

    curTag = "R9";
    tick(2);
    flipRead(); tick(4);
    check("R9", int'(rdyN), 1);
    tick(5);
    finishRun();
  end
endmodule